// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block moves configuration words between an external serial EEPROM and a small bank of on-chip registers. A load copies EEPROM words into the registers. A save writes register values back into the EEPROM. The host starts either operation by writing a control word. A load also starts on its own when reset is released. A select bit in the same control word picks one of two targets: a single general-purpose register, or the group made of the configuration, base and three station-address registers.

The EEPROM link is a four-wire serial interface. It has a chip select, a shift clock divided from the system clock, serial data to the device and serial data from the device. Each word is 16 bits at a 6-bit word address. While an operation runs the block raises a lock output and shields its registers from the host. The host can only poll the two busy bits in the control word. Host reads of any other address return zero, and host writes have no effect.

Top module: `eeprom_xfer_seq`

## Requirements
- R1: While reset is held and after it is released, bus_lock is high and a group load (select = 0) runs. It ends with bus_lock low within 37,500 clock cycles (750 us at 50 MHz).
- R2: A group load copies EEPROM word 0 to host address 1 (configuration) and word 1 to address 2 (base). It copies words 2, 3 and 4 to addresses 3, 4 and 5 (station address, low word first).
- R3: A group save writes address 1 to EEPROM word 0 and address 2 to word 1. No other EEPROM word changes.
- R4: With select = 1, a load or save moves only the general-purpose register (host address 6) to or from EEPROM word 32. The other registers and EEPROM words keep their values.
- R5: Control word at host address 0: bit 0 starts a save, bit 1 starts a load and bit 2 is the select. Both start bits clear by themselves when the operation completes. When idle, address 0 reads back select at bit 2 with all other bits zero.
- R6: While an operation runs, host address 0 reads with bits 1:0 = 2'b11. Every other host address reads as zero.
- R7: While an operation runs, host writes to any address, including the control word, have no effect. When idle, writes to addresses 1 to 6 are read back unchanged.
- R8: Each serial frame holds chip select high and shifts out MSB first, with data to the device stable while the shift clock is high. A frame is a start bit of 1, a 2-bit opcode and a 6-bit address. The opcodes are 10 = read, 01 = write, and 00 = write-enable with address 11xxxx. A read frame receives 16 data bits, MSB first.
- R9: Every saved word is preceded by its own write-enable frame. After a write frame, chip select is raised again, and no further shift clock edge is issued until data from the device reads 1 (ready).
- R10: A control write with both start bits set runs a load and no save.
- R11: bus_lock rises in the cycle after a control write that sets a start bit while idle. It stays high until the operation completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Host write strobe |
| cpu_addr | input | 3 | Host register address |
| cpu_wdata | input | 16 | Host write data |
| cpu_rdata | output | 16 | Host read data (combinational on cpu_addr) |
| bus_lock | output | 1 | High while a load or save is running |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data and ready flag from the EEPROM |

## Verification
A wrong word index or select decode surfaces at the end of an operation. A register reads back the wrong EEPROM word, or an EEPROM word outside the chosen group changes, and the bench compares both on the first idle cycle. A broken sequencing state shows on the serial pins within one frame: a frame with the wrong bit count or opcode, a write without a preceding enable, or a shift clock edge while the device is still busy. A faulty lock or read mask shows on cpu_rdata in the very clock after the start write, because the read path is compared on every cycle.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
  localparam int WORD_W    = 16;
  localparam int EE_AW     = 6;
  localparam int RID_W     = 3;
  localparam int HA_W      = 3;
  localparam int CMD_BITS  = 3 + EE_AW;
  localparam int FRAME_MAX = CMD_BITS + WORD_W;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  localparam logic [HA_W-1:0] HA_CTL = '0;
  localparam int CTL_STORE  = 0;
  localparam int CTL_RELOAD = 1;
  localparam int CTL_SEL    = 2;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_EWEN  = 2'b00;
  localparam logic [EE_AW-1:0] EWEN_ADDR  = 6'b110000;
  localparam logic [EE_AW-1:0] EE_GP_ADDR = 6'd32;

  localparam logic [RID_W-1:0] RID_GP = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_LAUNCH, S_EWEN, S_GAP_A, S_XFER, S_GAP_B, S_POLL, S_NEXT
  } seq_state_t;

  // register id of the idx-th word moved by an operation
  function automatic logic [RID_W-1:0] word_rid(input logic sel_gp,
                                                input logic [RID_W-1:0] idx);
    return sel_gp ? RID_GP : idx;
  endfunction

  // number of words an operation moves
  function automatic logic [RID_W-1:0] word_total(input logic sel_gp,
                                                  input logic is_store);
    if (sel_gp) return 3'd1;
    return is_store ? 3'd2 : 3'd5;
  endfunction

  function automatic logic [EE_AW-1:0] ee_addr_of(input logic [RID_W-1:0] rid);
    return (rid == RID_GP) ? EE_GP_ADDR : EE_AW'(rid);
  endfunction

  function automatic logic [FRAME_MAX-1:0] cmd_frame(input logic [1:0] op,
                                                     input logic [EE_AW-1:0] addr,
                                                     input logic [WORD_W-1:0] data);
    return {1'b1, op, addr, data};
  endfunction
endpackage

// File: rtl/mw_clkdiv.sv
module mw_clkdiv #(
  parameter int DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (!run || cnt == LAST)  cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/mw_frame.sv
module mw_frame
  import eeprom_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 start,
  input  logic [FRAME_MAX-1:0] tx,
  input  logic [CNT_W-1:0]     nbits,
  input  logic                 ee_do,
  output logic                 cs,
  output logic                 sk,
  output logic                 di,
  output logic                 done,
  output logic [WORD_W-1:0]    rx
);
  logic                 active;
  logic [FRAME_MAX-1:0] sh;
  logic [CNT_W-1:0]     left;
  logic                 last_bit;

  assign last_bit = (left == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sk     <= 1'b0;
      done   <= 1'b0;
      sh     <= '0;
      left   <= '0;
      rx     <= '0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        sk     <= 1'b0;
        sh     <= tx;
        left   <= nbits;
      end else if (active && tick) begin
        if (!sk) begin
          sk <= 1'b1;
          rx <= {rx[WORD_W-2:0], ee_do};
        end else begin
          sk <= 1'b0;
          if (last_bit) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            left <= left - 1'b1;
            sh   <= {sh[FRAME_MAX-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign cs = active;
  assign di = active & sh[FRAME_MAX-1];

  AST_SK_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sk |-> cs);  // R8
  AST_DI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && sk) |=> (!sk || $stable(di)));  // R8
endmodule

// File: rtl/ee_reg_file.sv
module ee_reg_file
  import eeprom_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              host_we,
  input  logic [RID_W-1:0]  host_rid,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              ld_en,
  input  logic [RID_W-1:0]  ld_rid,
  input  logic [WORD_W-1:0] ld_data,
  input  logic [RID_W-1:0]  rid_a,
  output logic [WORD_W-1:0] rd_a,
  input  logic [RID_W-1:0]  rid_b,
  output logic [WORD_W-1:0] rd_b
);
  localparam int NREG = int'(RID_GP) + 1;

  logic [NREG-1:0][WORD_W-1:0] regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      for (int k = 0; k < NREG; k++) begin
        if (ld_en && ld_rid == RID_W'(k))
          regs[k] <= ld_data;
        else if (host_we && !lock && host_rid == RID_W'(k))
          regs[k] <= host_wdata;
      end
    end
  end

  assign rd_a = (int'(rid_a) < NREG) ? regs[rid_a] : '0;
  assign rd_b = (int'(rid_b) < NREG) ? regs[rid_b] : '0;

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !ld_en) |=> $stable(regs));  // R7
endmodule

// File: rtl/eeprom_xfer_seq.sv
module eeprom_xfer_seq
  import eeprom_seq_pkg::*;
#(
  parameter int CLK_DIV = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [HA_W-1:0]   cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              bus_lock,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  seq_state_t           state;
  logic                 is_store;
  logic                 sel_gp;
  logic                 ewen_sent;
  logic [RID_W-1:0]     idx;

  logic                 tick;
  logic                 fr_start;
  logic                 fr_cs;
  logic                 fr_done;
  logic [FRAME_MAX-1:0] fr_tx;
  logic [CNT_W-1:0]     fr_nbits;
  logic [WORD_W-1:0]    fr_rx;
  logic [WORD_W-1:0]    st_data;
  logic [WORD_W-1:0]    host_rd;
  logic [RID_W-1:0]     cur_rid;
  logic [RID_W-1:0]     host_rid;
  logic [EE_AW-1:0]     cur_addr;

  // named internal events
  logic ctl_hit, op_start, last_word, op_finish, wr_start, ld_en, host_we;

  assign bus_lock  = (state != S_IDLE);
  assign cur_rid   = word_rid(sel_gp, idx);
  assign cur_addr  = ee_addr_of(cur_rid);
  assign host_rid  = RID_W'(cpu_addr - HA_W'(1));
  assign ctl_hit   = cpu_wr && (cpu_addr == HA_CTL);
  assign host_we   = cpu_wr && (cpu_addr != HA_CTL);
  assign op_start  = ctl_hit && !bus_lock &&
                     (cpu_wdata[CTL_RELOAD] || cpu_wdata[CTL_STORE]);
  assign last_word = (idx == word_total(sel_gp, is_store) - 1'b1);
  assign op_finish = (state == S_NEXT) && tick && last_word;
  assign wr_start  = (state == S_GAP_A) && tick;
  assign ld_en     = (state == S_XFER) && fr_done && !is_store;

  mw_clkdiv #(.DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(bus_lock), .tick(tick)
  );

  always_comb begin
    fr_start = 1'b0;
    fr_tx    = '0;
    fr_nbits = '0;
    if (state == S_LAUNCH) begin
      fr_start = 1'b1;
      if (is_store) begin
        fr_tx    = cmd_frame(OP_EWEN, EWEN_ADDR, '0);
        fr_nbits = CNT_W'(CMD_BITS);
      end else begin
        fr_tx    = cmd_frame(OP_READ, cur_addr, '0);
        fr_nbits = CNT_W'(FRAME_MAX);
      end
    end else if (wr_start) begin
      fr_start = 1'b1;
      fr_tx    = cmd_frame(OP_WRITE, cur_addr, st_data);
      fr_nbits = CNT_W'(FRAME_MAX);
    end
  end

  mw_frame u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(fr_start),
    .tx(fr_tx), .nbits(fr_nbits), .ee_do(ee_do),
    .cs(fr_cs), .sk(ee_sk), .di(ee_di), .done(fr_done), .rx(fr_rx)
  );

  ee_reg_file u_regs (
    .clk(clk), .rst_n(rst_n), .lock(bus_lock),
    .host_we(host_we), .host_rid(host_rid), .host_wdata(cpu_wdata),
    .ld_en(ld_en), .ld_rid(cur_rid), .ld_data(fr_rx),
    .rid_a(host_rid), .rd_a(host_rd),
    .rid_b(cur_rid), .rd_b(st_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_LAUNCH;
      is_store  <= 1'b0;
      sel_gp    <= 1'b0;
      idx       <= '0;
      ewen_sent <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (ctl_hit) begin
          sel_gp <= cpu_wdata[CTL_SEL];
          idx    <= '0;
          if (cpu_wdata[CTL_RELOAD]) begin
            is_store <= 1'b0;
            state    <= S_LAUNCH;
          end else if (cpu_wdata[CTL_STORE]) begin
            is_store <= 1'b1;
            state    <= S_LAUNCH;
          end
        end
        S_LAUNCH: state <= is_store ? S_EWEN : S_XFER;
        S_EWEN: if (fr_done) begin
          ewen_sent <= 1'b1;
          state     <= S_GAP_A;
        end
        S_GAP_A: if (tick) begin
          ewen_sent <= 1'b0;
          state     <= S_XFER;
        end
        S_XFER:  if (fr_done) state <= is_store ? S_GAP_B : S_NEXT;
        S_GAP_B: if (tick) state <= S_POLL;
        S_POLL:  if (ee_do) state <= S_NEXT;
        S_NEXT: if (tick) begin
          if (last_word) begin
            state <= S_IDLE;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_LAUNCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ee_cs = fr_cs | (state == S_POLL);

  always_comb begin
    if (bus_lock)
      cpu_rdata = (cpu_addr == HA_CTL) ? {{(WORD_W-2){1'b0}}, 2'b11} : '0;
    else if (cpu_addr == HA_CTL)
      cpu_rdata = {{(WORD_W-3){1'b0}}, sel_gp, 2'b00};
    else
      cpu_rdata = host_rd;
  end

  AST_START_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> bus_lock);  // R11
  AST_FINISH_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    op_finish |=> !bus_lock);  // R5
  AST_POLL_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POLL && !ee_do) |=> (state == S_POLL && ee_cs && !ee_sk));  // R9
  AST_EWEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> ewen_sent);  // R9
endmodule

// File: tb/eeprom_xfer_seq_tb.sv
module eeprom_xfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [2:0]  cpu_addr = 3'd0;
  logic [15:0] cpu_wdata = 16'h0;
  logic [15:0] cpu_rdata;
  logic        bus_lock, ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b1;

  always #10 clk = ~clk;

  eeprom_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .bus_lock(bus_lock),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- behavioural serial EEPROM ----------------
  logic [15:0] mem [64];
  logic [15:0] exp_mem [64];
  logic        wen = 1'b0, outmode = 1'b0, wr_pend = 1'b0;
  logic        sk_q = 1'b0, cs_q = 1'b0;
  logic [24:0] inb = '0;
  logic [15:0] outw = '0, wr_data = '0;
  logic [5:0]  wr_a = '0;
  int bitn = 0, busy = 0;
  int bad_frame = 0, early_sk = 0, bad_write = 0, ewen_cnt = 0;

  always @(negedge clk) begin
    if (busy > 0) busy--;
    if (ee_cs && !cs_q) begin bitn = 0; inb = '0; outmode = 1'b0; end
    if (ee_cs && ee_sk && !sk_q) begin
      if (busy > 0) early_sk++;
      inb = {inb[23:0], ee_di};
      bitn++;
      if (bitn == 9 && inb[8] && inb[7:6] == 2'b10) begin
        outmode = 1'b1; outw = mem[inb[5:0]];
      end
      if (bitn == 9 && inb[8] && inb[7:6] == 2'b00 && inb[5:4] == 2'b11) begin
        wen = 1'b1; ewen_cnt++;
      end
      if (bitn == 25 && inb[24] && inb[23:22] == 2'b01) begin
        wr_pend = 1'b1; wr_a = inb[21:16]; wr_data = inb[15:0];
      end
    end
    if (ee_cs && !ee_sk && sk_q && outmode) begin
      ee_do = outw[15]; outw = {outw[14:0], 1'b0};
    end
    if (!ee_cs && cs_q) begin
      if (bitn == 9) begin
        if (!(inb[8] && inb[7:6] == 2'b00 && inb[5:4] == 2'b11)) bad_frame++;
      end else if (bitn == 25) begin
        if (!(inb[24] && (inb[23:22] == 2'b10 || inb[23:22] == 2'b01))) bad_frame++;
      end else if (bitn != 0) bad_frame++;
      if (wr_pend) begin
        if (wen) mem[wr_a] = wr_data; else bad_write++;
        wen = 1'b0; wr_pend = 1'b0; busy = 40;
      end
      outmode = 1'b0;
    end
    if (!outmode) ee_do = (busy == 0);
    sk_q = ee_sk; cs_q = ee_cs;
  end

  // ---------------- reference register model ----------------
  logic [15:0] sh_reg [6];
  logic        sh_sel = 1'b0;
  logic        mon_en = 1'b0;
  logic        lock_q = 1'b0;

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    if (a == 3'd0) return {13'b0, sh_sel, 2'b00};
    if (a == 3'd7) return 16'h0;
    return sh_reg[a - 3'd1];
  endfunction

  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (bus_lock) begin
        if (cpu_addr == 3'd0) chk("R6 busy status", {14'b0, cpu_rdata[1:0]}, 16'h0003);
        else                  chk("R6 masked read", cpu_rdata, 16'h0000);
      end else if (!lock_q) begin
        chk("R7 idle readback", cpu_rdata, exp_rd(cpu_addr));
      end
    end
    lock_q = bus_lock;
  end

  // ---------------- stimulus helpers ----------------
  task automatic host_wr(input logic [2:0] a, input logic [15:0] d, input bit taken);
    @(posedge clk); #2;
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #2;
    cpu_wr = 1'b0;
    if (taken) begin
      if (a == 3'd0) sh_sel = d[2];
      else if (a != 3'd7) sh_reg[a - 3'd1] = d;
    end
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    @(posedge clk); #2;
    cpu_addr = a;
    @(negedge clk);
    chk(req, cpu_rdata, exp);
  endtask

  task automatic start_op(input logic [15:0] ctl);
    host_wr(3'd0, ctl, 1'b1);
    @(negedge clk);
    chk("R11 lock after start", {15'b0, bus_lock}, 16'h0001);
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (bus_lock && cyc < 60000);
  endtask

  task automatic chk_mem(input string req);
    for (int k = 0; k < 64; k++) chk(req, mem[k], exp_mem[k]);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int cyc;
    int ew0;
    for (int k = 0; k < 64; k++) begin
      mem[k] = 16'(k * 16'h0123 + 16'h00A5);
      exp_mem[k] = mem[k];
    end
    for (int k = 0; k < 6; k++) sh_reg[k] = 16'h0;
    cpu_addr = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 lock in reset", {15'b0, bus_lock}, 16'h0001);
    chk("R1 status in reset", cpu_rdata, 16'h0003);
    rst_n = 1'b1;
    wait_done(cyc);
    chk("R1 reset load time", 16'(cyc < 37500), 16'h0001);
    for (int k = 0; k < 5; k++) sh_reg[k] = mem[k];
    mon_en = 1'b1;
    for (int k = 1; k <= 5; k++) rd_chk("R2 reset load word", 3'(k), mem[k - 1]);
    rd_chk("R4 gp untouched by group load", 3'd6, 16'h0000);
    rd_chk("R5 status cleared", 3'd0, 16'h0000);

    // idle writes
    host_wr(3'd1, 16'h1234, 1'b1);
    host_wr(3'd2, 16'h5678, 1'b1);
    host_wr(3'd3, 16'h9ABC, 1'b1);
    host_wr(3'd6, 16'hBEEF, 1'b1);
    rd_chk("R7 idle write cfg", 3'd1, 16'h1234);
    rd_chk("R7 idle write gp", 3'd6, 16'hBEEF);

    // group save with lock-out probes
    ew0 = ewen_cnt;
    exp_mem[0] = 16'h1234; exp_mem[1] = 16'h5678;
    start_op(16'h0001);
    host_wr(3'd1, 16'hFFFF, 1'b0);
    host_wr(3'd0, 16'h0006, 1'b0);
    rd_chk("R6 masked during save", 3'd3, 16'h0000);
    rd_chk("R6 status during save", 3'd0, 16'h0003);
    wait_done(cyc);
    chk_mem("R3 group save");
    rd_chk("R7 write ignored while busy", 3'd1, 16'h1234);
    rd_chk("R7 control write ignored while busy", 3'd0, 16'h0000);
    chk("R9 enable per saved word", 16'(ewen_cnt - ew0), 16'h0002);

    // gp save
    exp_mem[32] = 16'hBEEF;
    start_op(16'h0005);
    wait_done(cyc);
    chk_mem("R4 gp save");
    rd_chk("R5 status after gp save", 3'd0, 16'h0004);

    // gp load
    mem[32] = 16'h1357; exp_mem[32] = 16'h1357;
    start_op(16'h0006);
    wait_done(cyc);
    sh_reg[5] = mem[32];
    rd_chk("R4 gp load", 3'd6, 16'h1357);
    rd_chk("R4 cfg untouched by gp load", 3'd1, 16'h1234);

    // both start bits: load wins
    mem[0] = 16'h2468; exp_mem[0] = 16'h2468;
    host_wr(3'd1, 16'h0F0F, 1'b1);
    start_op(16'h0003);
    wait_done(cyc);
    for (int k = 0; k < 5; k++) sh_reg[k] = mem[k];
    rd_chk("R10 load wins", 3'd1, 16'h2468);
    chk_mem("R10 no save");

    // fresh group load, MSB-first data
    for (int k = 0; k < 5; k++) begin
      mem[k] = 16'h8001 ^ 16'(k << 4);
      exp_mem[k] = mem[k];
    end
    start_op(16'h0002);
    wait_done(cyc);
    for (int k = 0; k < 5; k++) sh_reg[k] = mem[k];
    for (int k = 1; k <= 5; k++) rd_chk("R2 group load word", 3'(k), mem[k - 1]);
    chk_mem("R2 load leaves EEPROM");

    chk("R8 frame format", 16'(bad_frame), 16'h0000);
    chk("R9 clock while device busy", 16'(early_sk), 16'h0000);
    chk("R9 write without enable", 16'(bad_write), 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule